// File: doc/BRIEF.md
# I2C Four-Step Transaction Sequencer

This block is the user-side controller that sits in front of a byte-level I2C master. It runs one fixed transaction against one slave: a write, a read, a second write and a second read, all without a stop condition in between. The master takes a new command only at points set by its own bus timing, so the sequencer does not hand over commands on fixed clock cycles. Instead it watches the master's busy output. Each rising edge of busy means the master has just taken the command on offer, so the following command is put on the command lines at once.

The enable to the master stays high through the whole chain. It is released only once the master has taken the fourth command, so that the master ends with a stop. Each falling edge of busy marks the end of a command. When the command that just ended was a read, the returned byte is captured. After the final command ends, a one-cycle completion pulse is raised and the block goes idle again. A negative acknowledge reported at any command end sets a sticky error flag, which is cleared only by the next start request.

The slave address and the two bytes written are parameters. The rest of the addressing is left to the integrator.

Top module: `i2c_xact_seq`

## Requirements
- R1: After reset, `ena`, `done` and `err` are 0, and `rd_first` and `rd_second` are 0.
- R2: A `go` pulse seen on a clock edge while idle makes `ena` 1 from the next cycle. The first command is then on offer: `addr` = SLV_ADDR, `rw` = 0 (0 means write, 1 means read) and `wdata` = WR_A.
- R3: During a run, each rising edge of `busy` (sampled 0 on one clock edge, then 1 on the next) moves the offered command one step along the order write(WR_A), read, write(WR_B), read. The new command is visible in the cycle after that edge.
- R4: `ena` stays 1 from the start of a run until the fourth rising edge of `busy`, and is 0 from the cycle after that edge.
- R5: On the falling edge of `busy` that ends the second command, `rd_byte` is stored in `rd_first`. On the falling edge that ends the fourth command, `rd_byte` is stored in `rd_second`. Every other cycle leaves both registers unchanged.
- R6: The falling edge of `busy` that ends the fourth command raises `done` for exactly one cycle, in the cycle after that edge. The block is then idle.
- R7: If `ack_err` is 1 on any falling edge of `busy` that ends a command of a run, `err` becomes 1. It stays 1 until the next accepted `go`, which clears it in the following cycle.
- R8: `go` has no effect while a run is active: the offered command and `ena` are unchanged.
- R9: While idle, edges on `busy` have no effect: `done` stays 0, `ena` stays 0 and the read registers keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| go | input | 1 | Request to start the four-command transaction |
| busy | input | 1 | Busy indication from the I2C master |
| rd_byte | input | DW | Read data from the I2C master |
| ack_err | input | 1 | Acknowledge error from the I2C master |
| ena | output | 1 | Command enable to the I2C master |
| addr | output | AW | Slave address offered to the master |
| rw | output | 1 | Direction of the offered command (1 = read) |
| wdata | output | DW | Write byte offered to the master |
| rd_first | output | DW | Byte returned by the first read |
| rd_second | output | DW | Byte returned by the second read |
| done | output | 1 | One-cycle pulse when the transaction completes |
| err | output | 1 | Sticky acknowledge-error flag for the current run |

## Verification
Two things can fall on the same clock edge: the completion pulse of one run and the acceptance of a fresh start request. The bench provokes this by raising `go` in the very cycle in which `done` is seen high. Often the run that is ending has also reported a negative acknowledge on its last command. The bench then checks three things in the next cycle: `ena` is high again with the first write on offer, the error flag has been cleared, and the new run goes on to finish with its own read bytes.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  localparam int unsigned NCMD  = 4;
  localparam int unsigned NREAD = NCMD / 2;
  localparam int unsigned CW    = $clog2(NCMD + 1);

  // odd steps are reads, even steps are writes
  function automatic logic step_is_read(input int unsigned idx);
    return (idx % 2) == 1;
  endfunction

  // which write byte / read register a step belongs to
  function automatic int unsigned read_slot(input int unsigned idx);
    return idx / 2;
  endfunction

  // step on offer, clamped to the last command once the chain is spent
  function automatic int unsigned offer_step(input int unsigned cnt);
    return (cnt < NCMD) ? cnt : NCMD - 1;
  endfunction
endpackage

// File: rtl/i2c_seq_edge.sv
module i2c_seq_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic rise,
  output logic fall
);
  logic level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level;
  end

  assign rise = level & ~level_q;
  assign fall = ~level & level_q;
endmodule

// File: rtl/i2c_seq_ctrl.sv
module i2c_seq_ctrl
  import i2c_seq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          rise,
  input  logic          fall,
  input  logic          nack,
  output logic          start,
  output logic          run,
  output logic [CW-1:0] step,
  output logic          err,
  output logic          done
);
  logic finish;
  logic cmd_end;

  assign start   = go & ~run;
  assign cmd_end = run & fall & (step != '0);
  assign finish  = cmd_end & (step == CW'(NCMD));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= 1'b0;
      step <= '0;
      err  <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= finish;
      if (start) begin
        run  <= 1'b1;
        step <= '0;
        err  <= 1'b0;
      end else if (run) begin
        if (rise && (step < CW'(NCMD))) step <= step + CW'(1);
        if (cmd_end && nack) err <= 1'b1;
        if (finish) run <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/i2c_seq_capture.sv
module i2c_seq_capture
  import i2c_seq_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      run,
  input  logic                      fall,
  input  logic [CW-1:0]             step,
  input  logic [DW-1:0]             rd_in,
  output logic [NREAD-1:0][DW-1:0]  rd_regs
);
  logic        ended_valid;
  int unsigned ended_idx;

  always_comb begin
    ended_valid = run && fall && (step != '0);
    ended_idx   = (step != '0) ? int'(step) - 1 : 0;
  end

  for (genvar g = 0; g < NREAD; g++) begin : g_slot
    logic hit;
    assign hit = ended_valid && step_is_read(ended_idx) &&
                 (read_slot(ended_idx) == g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   rd_regs[g] <= '0;
      else if (hit) rd_regs[g] <= rd_in;
    end
  end
endmodule

// File: rtl/i2c_xact_seq.sv
module i2c_xact_seq
  import i2c_seq_pkg::*;
#(
  parameter int unsigned AW       = 7,
  parameter int unsigned DW       = 8,
  parameter logic [6:0]  SLV_ADDR = 7'h2A,
  parameter logic [7:0]  WR_A     = 8'h10,
  parameter logic [7:0]  WR_B     = 8'h20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          busy,
  input  logic [DW-1:0] rd_byte,
  input  logic          ack_err,
  output logic          ena,
  output logic [AW-1:0] addr,
  output logic          rw,
  output logic [DW-1:0] wdata,
  output logic [DW-1:0] rd_first,
  output logic [DW-1:0] rd_second,
  output logic          done,
  output logic          err
);
  logic                     rise_w;
  logic                     fall_w;
  logic                     start_w;
  logic                     run_w;
  logic [CW-1:0]            step_w;
  logic [NREAD-1:0][DW-1:0] rd_regs;
  int unsigned              stage_idx;

  i2c_seq_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .level (busy),
    .rise  (rise_w),
    .fall  (fall_w)
  );

  i2c_seq_ctrl u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (go),
    .rise  (rise_w),
    .fall  (fall_w),
    .nack  (ack_err),
    .start (start_w),
    .run   (run_w),
    .step  (step_w),
    .err   (err),
    .done  (done)
  );

  i2c_seq_capture #(.DW(DW)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run_w),
    .fall    (fall_w),
    .step    (step_w),
    .rd_in   (rd_byte),
    .rd_regs (rd_regs)
  );

  always_comb begin
    stage_idx = offer_step(int'(step_w));
    ena       = run_w && (step_w < CW'(NCMD));
    addr      = AW'(SLV_ADDR);
    rw        = step_is_read(stage_idx);
    wdata     = (read_slot(stage_idx) == 0) ? DW'(WR_A) : DW'(WR_B);
  end

  assign rd_first  = rd_regs[0];
  assign rd_second = rd_regs[NREAD-1];
endmodule

// File: rtl/i2c_seq_chk.sv
module i2c_seq_chk
  import i2c_seq_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ena,
  input logic          done,
  input logic          err,
  input logic          start,
  input logic          run,
  input logic          rise,
  input logic          fall,
  input logic [CW-1:0] step,
  input logic [DW-1:0] rd_first,
  input logic [DW-1:0] rd_second
);
  p_step_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !start && rise && (step < CW'(NCMD))) |=> (step == $past(step) + CW'(1)));

  p_ena_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !start && rise && (step == CW'(NCMD - 1))) |=> !ena);

  p_rd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> ($stable(rd_first) && $stable(rd_second)));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!ena && !run));

  p_err_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !start) |=> err);

  p_err_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!err && ena));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !start) |=> (!done && !ena));
endmodule

bind i2c_xact_seq i2c_seq_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ena       (ena),
  .done      (done),
  .err       (err),
  .start     (start_w),
  .run       (run_w),
  .rise      (rise_w),
  .fall      (fall_w),
  .step      (step_w),
  .rd_first  (rd_first),
  .rd_second (rd_second)
);

// File: tb/tb_i2c_xact_seq.sv
module tb_i2c_xact_seq;
  localparam logic [6:0] SLV  = 7'h2A;
  localparam logic [7:0] WA   = 8'h10;
  localparam logic [7:0] WB   = 8'h20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       go = 1'b0;
  logic       busy = 1'b0;
  logic [7:0] rd_byte = 8'h00;
  logic       ack_err = 1'b0;
  logic       ena, rw, done, err;
  logic [6:0] addr;
  logic [7:0] wdata, rd_first, rd_second;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  i2c_xact_seq #(.SLV_ADDR(SLV), .WR_A(WA), .WR_B(WB)) dut (
    .clk(clk), .rst_n(rst_n), .go(go), .busy(busy), .rd_byte(rd_byte),
    .ack_err(ack_err), .ena(ena), .addr(addr), .rw(rw), .wdata(wdata),
    .rd_first(rd_first), .rd_second(rd_second), .done(done), .err(err)
  );

  function automatic logic exp_rw(input int k);
    return (k % 2) == 1;
  endfunction

  function automatic logic [7:0] exp_wd(input int k);
    return (k < 2) ? WA : WB;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  task automatic check_offer(input int k, input string req);
    chk(ena === 1'b1, req, 32'(ena), 1);
    chk(addr === SLV, req, 32'(addr), 32'(SLV));
    chk(rw === exp_rw(k), req, 32'(rw), 32'(exp_rw(k)));
    if (!exp_rw(k)) chk(wdata === exp_wd(k), req, 32'(wdata), 32'(exp_wd(k)));
  endtask

  // One full transaction. skip_go: start already accepted by caller.
  // chain_next: raise go in the cycle done is seen.
  task automatic do_run(input logic [7:0] b0, input logic [7:0] b1,
                        input logic [3:0] nk, input bit skip_go,
                        input bit chain_next);
    logic [7:0] keep0, keep1;
    if (!skip_go) begin
      @(negedge clk) go = 1'b1;
      @(negedge clk) go = 1'b0;
      chk(err === 1'b0, "R7 err cleared by go", 32'(err), 0);
    end
    check_offer(0, "R2 first command");
    for (int k = 0; k < 4; k++) begin
      int gap = int'($urandom_range(0, 3));
      int hold = int'($urandom_range(2, 6));
      for (int i = 0; i < gap; i++) begin
        @(negedge clk);
        chk(ena === 1'b1, "R4 ena held", 32'(ena), 1);
      end
      busy = 1'b1;
      @(negedge clk);
      if (k < 3) check_offer(k + 1, "R3 next staged");
      else chk(ena === 1'b0, "R4 ena dropped", 32'(ena), 0);
      for (int i = 0; i < hold; i++) begin
        if (k == 1 && i == 0) go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        if (k == 1 && i == 0) check_offer(2, "R8 go ignored");
      end
      keep0 = rd_first;
      keep1 = rd_second;
      rd_byte = (k == 1) ? b0 : (k == 3) ? b1 : 8'($urandom);
      ack_err = nk[k];
      busy = 1'b0;
      @(negedge clk);
      ack_err = 1'b0;
      if (k == 1) chk(rd_first === b0, "R5 first read", 32'(rd_first), 32'(b0));
      else if (k == 3) begin
        chk(rd_second === b1, "R5 second read", 32'(rd_second), 32'(b1));
        chk(rd_first === keep0, "R5 first kept", 32'(rd_first), 32'(keep0));
        chk(done === 1'b1, "R6 done raised", 32'(done), 1);
        chk(err === (|nk), "R7 err flag", 32'(err), 32'(|nk));
        if (chain_next) go = 1'b1;
      end else begin
        chk(rd_first === keep0, "R5 no capture on write", 32'(rd_first), 32'(keep0));
        chk(rd_second === keep1, "R5 no capture on write", 32'(rd_second), 32'(keep1));
        chk(done === 1'b0, "R6 no early done", 32'(done), 0);
      end
    end
    @(negedge clk);
    go = 1'b0;
    chk(done === 1'b0, "R6 done one cycle", 32'(done), 0);
    if (chain_next) begin
      check_offer(0, "R2 restart in done cycle");
      chk(err === 1'b0, "R7 err cleared on restart", 32'(err), 0);
    end else begin
      chk(ena === 1'b0, "R6 idle after done", 32'(ena), 0);
    end
  endtask

  initial begin
    #(20 * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finish");
    finish_up();
  end

  initial begin
    logic [7:0] k0, k1;
    void'($urandom(32'd1234));
    #1;
    chk(ena === 1'b0 && done === 1'b0 && err === 1'b0, "R1 reset controls",
        {29'd0, ena, done, err}, 0);
    chk(rd_first === 8'h00 && rd_second === 8'h00, "R1 reset reads",
        {16'd0, rd_first, rd_second}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ena === 1'b0, "R1 idle after reset", 32'(ena), 0);

    // directed: clean run, then a run with a nack chained into a restart
    do_run(8'hA5, 8'h5A, 4'b0000, 1'b0, 1'b0);
    do_run(8'h00, 8'hFF, 4'b1000, 1'b0, 1'b1);
    do_run(8'h3C, 8'hC3, 4'b0010, 1'b1, 1'b0);

    // R9: busy activity while idle
    k0 = rd_first;
    k1 = rd_second;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk) begin busy = 1'b1; rd_byte = 8'($urandom); end
      @(negedge clk) busy = 1'b0;
      @(negedge clk);
      chk(done === 1'b0 && ena === 1'b0, "R9 idle busy ignored",
          {30'd0, done, ena}, 0);
      chk(rd_first === k0 && rd_second === k1, "R9 reads kept",
          {16'd0, rd_first, rd_second}, {16'd0, k0, k1});
    end

    // random runs
    for (int r = 0; r < 8; r++) begin
      do_run(8'($urandom), 8'($urandom), 4'($urandom) & 4'($urandom),
             1'b0, 1'b0);
    end
    finish_up();
  end
endmodule